// File: doc/BRIEF.md
# Dynamic-Width Multiplexed External Bus Controller

This block turns single memory requests from a 16-bit core into cycles on a multiplexed external address/data bus. Each cycle first drives a byte address on the shared lines, then runs a read or write data phase under a read or write strobe. The bus runs 8 or 16 bits wide, and the width is chosen again on every cycle. When dynamic width is enabled, the controller samples the bus-width input right after the address tick. When it is disabled, every cycle is 8 bits wide. A word access that ends up on a byte-wide cycle is completed as a second byte cycle at the odd address.

Time is counted in oscillator ticks, one clock per tick. A cycle with no waits takes four ticks: address, two strobe ticks and a closing tick. The ready input is sampled at the end of the second strobe tick, and again at the end of every second wait tick. Each wait it grants costs two ticks.

Three configuration inputs set how the pins behave. The first enables dynamic width. The second turns the two write pins into per-byte write strobes instead of a plain write strobe plus a high-byte enable. The third changes the address pin from a one-tick latch pulse into an active-low address-valid level. A fetch indicator marks instruction fetches for the whole access. The core receives a one-tick done pulse in the final tick, with read data already packed into 16 bits.

Top module: `ext_bus_ctrl`

## Requirements
- R1: With `cfg_dyn_width`=1 and `buswidth`=1 sampled after the address tick, a word access takes one 16-bit cycle. With `buswidth`=0, or with `cfg_dyn_width`=0, each requested byte gets its own cycle, and the even byte goes first.
- R2: A cycle lasts 4 ticks plus 2 ticks per wait state. `ready` is sampled at the end of the third tick of the cycle and at the end of every second wait tick, and a low value adds one wait.
- R3: `ready` has no effect while the controller is idle, or during the address tick and the first strobe tick of a cycle.
- R4: With `cfg_byte_strobes`=0, `wr_n` is low on every strobe tick of a write. With `cfg_byte_strobes`=1, it is low only on the strobe ticks of cycles that write the even byte.
- R5: With `cfg_byte_strobes`=0, `bhe_n` is low for every tick of each write cycle whose access includes the odd byte. With `cfg_byte_strobes`=1, it is low only on the strobe ticks of cycles that write the odd byte.
- R6: With `cfg_adv`=0, `ale_adv` is high only in the address tick of each cycle. With `cfg_adv`=1, it is low from the address tick through the strobe ticks, and high in the closing tick and while idle.
- R7: `inst` is high on every tick of a fetch access, and low on every tick of a data access and while idle.
- R8: `rd_n` is low on exactly the strobe ticks of read cycles. While idle, all strobes are high and `ad_oe` is 0.
- R9: `done` is a one-tick pulse in the closing tick of the last cycle. `rdata[7:0]` holds the even byte and `rdata[15:8]` the odd byte, and any byte that was not requested reads as 0.
- R10: The address tick drives the byte address: even when byte enable 0 is set, odd otherwise. A 16-bit write drives both lanes. A byte-wide write drives the selected byte on `ad_out[7:0]`.
- R11: Reset, applied at any time, returns the controller to idle at once: `busy`=0, `done`=0, all strobes high, `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken while idle |
| req_word | input | 15 | Word address of the access |
| req_wdata | input | 16 | Write data, odd byte in [15:8] |
| req_be | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte, at least one set |
| req_write | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | 1 instruction fetch, 0 data |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final-tick completion pulse |
| rdata | output | 16 | Packed read data |
| cfg_dyn_width | input | 1 | Enable per-cycle width sampling |
| cfg_byte_strobes | input | 1 | Per-byte write strobe pin mode |
| cfg_adv | input | 1 | Address-valid level instead of latch pulse |
| buswidth | input | 1 | 1 requests a 16-bit cycle |
| ready | input | 1 | Low adds wait states |
| ale_adv | output | 1 | Address latch pulse or active-low address valid |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe or even-byte write strobe |
| bhe_n | output | 1 | High-byte enable or odd-byte write strobe |
| inst | output | 1 | Fetch indicator |
| ad_out | output | 16 | Address/data lines driven out |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| ad_in | input | 16 | Address/data lines read in |

## Verification
Two functions meet at one sampling point: wait-state extension and read-data capture. The tick that samples `ready` is also the tick that latches the returned bytes. A byte-split word read can therefore stretch its first cycle and then start a second cycle, with `ready` held low again through that cycle's address and first strobe tick. The bench provokes this by driving `ready` from the tick position inside each cycle, which it tracks from the address pulse it observes. It then judges the total tick count, the strobe-low tick counts and the assembled read word against values computed from the vector alone. Width selection and write-pin mode are crossed in the same vectors, so split and 16-bit cycles are checked under both strobe conventions.

// File: rtl/ext_bus_ctrl.sv
`timescale 1ns/1ps
module ext_bus_ctrl #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [2*LANE_W-2:0]   req_word,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_be,
  input  logic                  req_write,
  input  logic                  req_fetch,
  output logic                  busy,
  output logic                  done,
  output logic [2*LANE_W-1:0]   rdata,
  input  logic                  cfg_dyn_width,
  input  logic                  cfg_byte_strobes,
  input  logic                  cfg_adv,
  input  logic                  buswidth,
  input  logic                  ready,
  output logic                  ale_adv,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic                  bhe_n,
  output logic                  inst,
  output logic [2*LANE_W-1:0]   ad_out,
  output logic                  ad_oe,
  input  logic [2*LANE_W-1:0]   ad_in
);
  localparam int BUS_W = 2 * LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_S1, ST_S2, ST_W1, ST_W2, ST_END
  } st_t;

  st_t                st;
  logic [BUS_W-2:0]   word_q;
  logic               idx_q;
  logic [1:0]         be_q;
  logic [BUS_W-1:0]   wd_q;
  logic [BUS_W-1:0]   rd_q;
  logic               wr_q, fe_q, w16_q;

  logic strobe, lo_cov, hi_cov, want_hi, last;

  assign busy    = (st != ST_IDLE);
  assign strobe  = (st == ST_S1) || (st == ST_S2) || (st == ST_W1) || (st == ST_W2);
  assign lo_cov  = ~idx_q;
  assign hi_cov  = w16_q ? be_q[1] : idx_q;
  assign want_hi = idx_q | be_q[1];
  assign last    = w16_q | idx_q | ~be_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      word_q <= '0;
      idx_q  <= 1'b0;
      be_q   <= 2'b00;
      wd_q   <= '0;
      rd_q   <= '0;
      wr_q   <= 1'b0;
      fe_q   <= 1'b0;
      w16_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req) begin
          word_q <= req_word;
          idx_q  <= ~req_be[0];
          be_q   <= req_be;
          wd_q   <= req_wdata;
          wr_q   <= req_write;
          fe_q   <= req_fetch;
          rd_q   <= '0;
          st     <= ST_ADDR;
        end
        ST_ADDR: begin
          w16_q <= cfg_dyn_width & buswidth;
          st    <= ST_S1;
        end
        ST_S1: st <= ST_S2;
        ST_S2, ST_W2: begin
          if (ready) begin
            if (!wr_q) begin
              if (w16_q) begin
                if (lo_cov) rd_q[LANE_W-1:0]     <= ad_in[LANE_W-1:0];
                if (hi_cov) rd_q[BUS_W-1:LANE_W] <= ad_in[BUS_W-1:LANE_W];
              end else if (idx_q) begin
                rd_q[BUS_W-1:LANE_W] <= ad_in[LANE_W-1:0];
              end else begin
                rd_q[LANE_W-1:0] <= ad_in[LANE_W-1:0];
              end
            end
            st <= ST_END;
          end else begin
            st <= ST_W1;
          end
        end
        ST_W1: st <= ST_W2;
        ST_END: begin
          if (last) st <= ST_IDLE;
          else begin
            idx_q <= 1'b1;
            st    <= ST_ADDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done  = (st == ST_END) && last;
  assign rdata = rd_q;
  assign inst  = busy & fe_q;
  assign rd_n  = ~(strobe & ~wr_q);
  assign wr_n  = ~(strobe & wr_q & (~cfg_byte_strobes | lo_cov));
  assign bhe_n = cfg_byte_strobes ? ~(strobe & wr_q & hi_cov)
                                  : ~(busy & wr_q & want_hi);
  assign ale_adv = cfg_adv ? ~(busy & (st != ST_END)) : (st == ST_ADDR);
  assign ad_oe = (st == ST_ADDR) | (busy & wr_q);
  assign ad_out = (st == ST_ADDR) ? {word_q, idx_q} :
                  (busy & wr_q)   ? {wd_q[BUS_W-1:LANE_W],
                                     (idx_q & ~w16_q) ? wd_q[BUS_W-1:LANE_W] : wd_q[LANE_W-1:0]} :
                                    '0;
endmodule

// File: rtl/ext_bus_ctrl_chk.sv
`timescale 1ns/1ps
module ext_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_n,
  input logic wr_n,
  input logic bhe_n,
  input logic inst,
  input logic ad_oe,
  input logic ale_adv,
  input logic cfg_adv
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && bhe_n && !ad_oe && !inst));

  assert_no_rd_wr_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_n && !ad_oe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_strobes_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && busy));

  assert_inst_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(inst));

  assert_ale_with_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv && ale_adv) |-> (ad_oe && rd_n && wr_n));
endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_n(rd_n),
  .wr_n(wr_n), .bhe_n(bhe_n), .inst(inst), .ad_oe(ad_oe),
  .ale_adv(ale_adv), .cfg_adv(cfg_adv)
);

// File: tb/ext_bus_ctrl_tb.sv
`timescale 1ns/1ps
module ext_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [14:0] req_word = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        req_write = 1'b0, req_fetch = 1'b0;
  logic        busy, done;
  logic [15:0] rdata;
  logic        cfg_dyn_width = 1'b0, cfg_byte_strobes = 1'b0, cfg_adv = 1'b0;
  logic        buswidth = 1'b0, ready = 1'b0;
  logic        ale_adv, rd_n, wr_n, bhe_n, inst, ad_oe;
  logic [15:0] ad_out;
  logic [15:0] ad_in = '0;

  always #2.5 clk = ~clk;

  ext_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_word(req_word), .req_wdata(req_wdata),
    .req_be(req_be), .req_write(req_write), .req_fetch(req_fetch), .busy(busy),
    .done(done), .rdata(rdata), .cfg_dyn_width(cfg_dyn_width),
    .cfg_byte_strobes(cfg_byte_strobes), .cfg_adv(cfg_adv), .buswidth(buswidth),
    .ready(ready), .ale_adv(ale_adv), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .inst(inst), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  typedef struct packed {
    logic dyn, split, adv, bw, fetch, write;
    logic [1:0] be;
    logic [1:0] waits;
    logic [15:0] addr;
    logic [15:0] wdata;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b11,2'd0,16'h1234,16'h0000},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'd0,16'h2346,16'h0000},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'b11,2'd1,16'h4000,16'h0000},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b11,2'd2,16'h8002,16'h0000},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,2'd0,16'h1000,16'hBEEF},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,2'd0,16'h1010,16'hCAFE},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b11,2'd1,16'h2020,16'h1357},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,2'd0,16'h3030,16'h2468},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,2'b10,2'd0,16'h4040,16'hAB00},
    '{0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b10,2'd1,16'h5050,16'h7700},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'd0,16'h6060,16'h0000},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,2'b01,2'd3,16'h7070,16'h0000},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,2'd0,16'h8080,16'h0000},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,2'b01,2'd0,16'h9090,16'h00A5}
  };

  int nchk = 0, nbad = 0;

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got=%0h expected=%0h", what, got, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic run_vec(input vec_t v, input int id);
    int ticks = 0, ncyc = 0, pos = 0, w = int'(v.waits);
    int n_rd = 0, n_wr = 0, n_bhe = 0, n_inst = 0, n_ale = 0;
    int exp_cyc, s_t, t_t, e_wr, e_bhe;
    logic prev_ale;
    logic [15:0] first_a = '0, cur_a = '0, got_rd = '0, e_rd;
    logic [7:0] glo = '0, ghi = '0;
    bit w16, seen_done = 0;
    @(negedge clk);
    cfg_dyn_width = v.dyn; cfg_byte_strobes = v.split; cfg_adv = v.adv;
    buswidth = v.bw; req_word = v.addr[15:1]; req_wdata = v.wdata;
    req_be = v.be; req_write = v.write; req_fetch = v.fetch; req = 1'b1;
    prev_ale = v.adv;
    w16 = v.dyn & v.bw;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 200; k++) begin
      ticks++;
      if (v.adv ? (prev_ale && !ale_adv) : ale_adv) begin
        ncyc++; pos = 1; cur_a = ad_out;
        if (ncyc == 1) first_a = ad_out;
        ad_in = cur_a[0] ? {mem_byte(cur_a), mem_byte(cur_a)}
                         : {mem_byte(cur_a | 16'h1), mem_byte(cur_a)};
      end else pos++;
      ready = (pos >= ((ncyc == 1) ? 3 + 2*w : 3));
      if (!rd_n) n_rd++;
      if (!wr_n) n_wr++;
      if (!bhe_n) n_bhe++;
      if (inst) n_inst++;
      if (ale_adv) n_ale++;
      if (pos == 2 && v.write) begin
        if (w16) begin
          if (v.be[0] && !cur_a[0]) glo = ad_out[7:0];
          if (v.be[1]) ghi = ad_out[15:8];
        end else if (cur_a[0]) ghi = ad_out[7:0];
        else glo = ad_out[7:0];
      end
      prev_ale = ale_adv;
      if (done) begin got_rd = rdata; seen_done = 1; break; end
      @(negedge clk);
    end
    ready = 1'b0;
    chk(seen_done, $sformatf("R9 vec%0d done seen", id), seen_done, 1);
    exp_cyc = w16 ? 1 : ((v.be == 2'b11) ? 2 : 1);
    s_t = 2*exp_cyc + 2*w;
    t_t = 4*exp_cyc + 2*w;
    chk(ncyc == exp_cyc, $sformatf("R1 vec%0d bus cycles", id), ncyc, exp_cyc);
    chk(ticks == t_t, $sformatf("R2 vec%0d ticks", id), ticks, t_t);
    if (w == 0) chk(ticks == 4*exp_cyc, $sformatf("R3 vec%0d ready low idle/early ignored", id), ticks, 4*exp_cyc);
    chk(first_a == {v.addr[15:1], ~v.be[0]}, $sformatf("R10 vec%0d address", id), first_a, {v.addr[15:1], ~v.be[0]});
    chk(n_ale == exp_cyc, $sformatf("R6 vec%0d ale/adv high ticks", id), n_ale, exp_cyc);
    chk(n_inst == (v.fetch ? t_t : 0), $sformatf("R7 vec%0d inst ticks", id), n_inst, v.fetch ? t_t : 0);
    chk(n_rd == (v.write ? 0 : s_t), $sformatf("R8 vec%0d rd ticks", id), n_rd, v.write ? 0 : s_t);
    e_wr = !v.write ? 0 : (v.split ? (v.be[0] ? 2 + 2*w : 0) : s_t);
    chk(n_wr == e_wr, $sformatf("R4 vec%0d wr ticks", id), n_wr, e_wr);
    e_bhe = !v.write ? 0 : v.split ? (v.be[1] ? ((w16 || !v.be[0]) ? 2 + 2*w : 2) : 0)
                                   : (v.be[1] ? t_t : 0);
    chk(n_bhe == e_bhe, $sformatf("R5 vec%0d bhe ticks", id), n_bhe, e_bhe);
    if (v.write) begin
      chk(glo == (v.be[0] ? v.wdata[7:0] : 8'h00), $sformatf("R10 vec%0d even write byte", id), glo, v.be[0] ? v.wdata[7:0] : 8'h00);
      chk(ghi == (v.be[1] ? v.wdata[15:8] : 8'h00), $sformatf("R10 vec%0d odd write byte", id), ghi, v.be[1] ? v.wdata[15:8] : 8'h00);
    end else begin
      e_rd = {v.be[1] ? mem_byte({v.addr[15:1], 1'b1}) : 8'h00,
              v.be[0] ? mem_byte({v.addr[15:1], 1'b0}) : 8'h00};
      chk(got_rd == e_rd, $sformatf("R9 vec%0d read data", id), got_rd, e_rd);
    end
    @(negedge clk);
    chk(!done && !busy, $sformatf("R9 vec%0d done one tick, back idle", id), {done, busy}, 0);
  endtask

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog expired: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && rd_n && wr_n && bhe_n && !ad_oe && !inst && !ale_adv,
        "R11 reset idle state (ALE mode)", {busy, done, rd_n, wr_n, bhe_n, ad_oe, inst, ale_adv}, 8'b00111000);
    cfg_adv = 1'b1;
    #1;
    chk(ale_adv == 1'b1, "R6 ADV level high while idle", ale_adv, 1);
    cfg_adv = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && rd_n && wr_n && !ad_oe, "R11 idle after reset release", {busy, rd_n, wr_n, ad_oe}, 4'b0110);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    @(negedge clk);
    cfg_dyn_width = 1'b1; buswidth = 1'b1; cfg_byte_strobes = 1'b0; cfg_adv = 1'b0;
    req_word = 15'h0100; req_be = 2'b11; req_write = 1'b0; req_fetch = 1'b1; req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk(!rd_n && inst, "R8 read strobe low in first strobe tick", {rd_n, inst}, 2'b01);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && rd_n && wr_n && bhe_n && !ad_oe && !inst,
        "R11 reset mid-access returns idle", {busy, rd_n, wr_n, bhe_n, ad_oe, inst}, 6'b011100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && rd_n, "R11 stays idle after mid-access reset", {busy, rd_n}, 2'b01);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule